// File: doc/BRIEF.md
# Dual-Operand Multiply-Accumulate Address Generator

This block forms the two operand addresses that a multiply-accumulate style instruction needs in one cycle. One address lies in X data space and one in Y data space. Each operand names a pointer register by number. Registers 8 and 9 always feed the X lane. Registers 10 and 11 always feed the Y lane. The caller supplies the current values of those four pointers, one shared offset value, and for each operand a mode code and a direction bit.

Each lane returns the access address and the post-modified pointer value. It also returns a write-back enable and the number of the register to write. The two lanes work in parallel and do not affect each other. A configuration error flag reports an illegal register or mode. A range error flag reports an address or updated pointer that falls outside its space's window. Either error blocks write-back in the lane that caused it. All outputs are registered, so they appear one clock after the inputs are sampled.

Top module: `mac_agu`

## Requirements
- R1: While rst_ni is low, every output is zero.
- R2: The X operand accepts only register 8 or 9, and the Y operand accepts only register 10 or 11. Any other register number sets cfg_err_o and clears that lane's write-back enable.
- R3: Mode 0 (indirect) gives address = pointer and write-back value = pointer, with the write-back enable low.
- R4: Modes 1, 2 and 3 step the pointer by 2, 4 and 6. The step subtracts when the direction bit is 1 and adds when it is 0. The address is the old pointer, and the write-back value is the stepped pointer. The enable is high when the lane has no error, and the echoed register number is the selected one.
- R5: Mode 4 (indexed) gives address = pointer + offset_i, write-back value = pointer, and the enable low. It is legal only on register 9 or 11. Mode 4 on register 8 or 10, and any mode code from 5 to 7, sets cfg_err_o.
- R6: Bit 0 of every address and write-back value is zero.
- R7: If the access address, or the stepped pointer in modes 1 to 3, lies outside [LO, HI] of that lane's space, range_err_o is set and that lane's enable is low.
- R8: An error in one lane does not stop write-back in the other lane.
- R9: Outputs reflect the inputs present at the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_sel_i | input | 4 | Register number for the X operand |
| x_mode_i | input | 3 | X addressing mode code |
| x_dec_i | input | 1 | X post-modify direction, 1 = decrement |
| y_sel_i | input | 4 | Register number for the Y operand |
| y_mode_i | input | 3 | Y addressing mode code |
| y_dec_i | input | 1 | Y post-modify direction, 1 = decrement |
| ptr_x0_i | input | 16 | Value of register 8 |
| ptr_x1_i | input | 16 | Value of register 9 |
| ptr_y0_i | input | 16 | Value of register 10 |
| ptr_y1_i | input | 16 | Value of register 11 |
| offset_i | input | 16 | Index offset register value |
| x_addr_o | output | 16 | X access address |
| x_wb_o | output | 16 | X pointer write-back value |
| x_we_o | output | 1 | X write-back enable |
| x_wb_reg_o | output | 4 | X write-back register number |
| y_addr_o | output | 16 | Y access address |
| y_wb_o | output | 16 | Y pointer write-back value |
| y_we_o | output | 1 | Y write-back enable |
| y_wb_reg_o | output | 4 | Y write-back register number |
| cfg_err_o | output | 1 | Illegal register or mode in either lane |
| range_err_o | output | 1 | Address or stepped pointer outside its window |

## Verification
The bench builds the block with a narrow X window of 0x0100 to 0x01FF and a Y window of 0x0200 to 0x02FF. It keeps the default 16-bit width and register numbers 8 to 11. The small windows put both edges of each space within one or two steps of ordinary pointer values. This makes it possible to test a step that just reaches the upper edge, a step that crosses it, a decrement below the lower edge, and an indexed access that overshoots.

// File: rtl/mac_agu_pkg.sv
package mac_agu_pkg;
  typedef enum logic [2:0] {
    AM_IND   = 3'd0,
    AM_POST2 = 3'd1,
    AM_POST4 = 3'd2,
    AM_POST6 = 3'd3,
    AM_INDEX = 3'd4
  } amode_e;

  localparam int unsigned NLANE = 2;
endpackage

// File: rtl/mac_agu_win.sv
module mac_agu_win #(
  parameter int unsigned  AW = 16,
  parameter logic [AW-1:0] LO = '0,
  parameter logic [AW-1:0] HI = '1
) (
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] b_i,
  input  logic          b_en_i,
  output logic          out_o
);
  logic a_in, b_in;
  assign a_in  = (a_i >= LO) && (a_i <= HI);
  assign b_in  = (b_i >= LO) && (b_i <= HI);
  assign out_o = !a_in || (b_en_i && !b_in);
endmodule

// File: rtl/mac_agu_lane.sv
module mac_agu_lane
  import mac_agu_pkg::*;
#(
  parameter int unsigned   AW    = 16,
  parameter int unsigned   RW    = 4,
  parameter logic [RW-1:0] REG_A = 4'd8,
  parameter logic [RW-1:0] REG_B = 4'd9,
  parameter logic [AW-1:0] LO    = '0,
  parameter logic [AW-1:0] HI    = '1
) (
  input  logic [RW-1:0] sel_i,
  input  logic [2:0]    mode_i,
  input  logic          dec_i,
  input  logic [AW-1:0] ptr_a_i,
  input  logic [AW-1:0] ptr_b_i,
  input  logic [AW-1:0] off_i,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] nxt_o,
  output logic          we_o,
  output logic          cfg_err_o,
  output logic          rng_err_o
);
  localparam logic [AW-1:0] EVEN = {{(AW-1){1'b1}}, 1'b0};

  logic [AW-1:0] ptr, step, ea_raw, nxt_raw;
  logic          is_b, reg_ok, post, idx, mode_ok;

  assign is_b   = (sel_i == REG_B);
  assign reg_ok = is_b || (sel_i == REG_A);
  assign ptr    = is_b ? ptr_b_i : ptr_a_i;

  always_comb begin
    step = '0;
    post = 1'b0;
    idx  = 1'b0;
    mode_ok = 1'b1;
    unique case (mode_i)
      AM_IND:   ;
      AM_POST2: begin step = AW'(2); post = 1'b1; end
      AM_POST4: begin step = AW'(4); post = 1'b1; end
      AM_POST6: begin step = AW'(6); post = 1'b1; end
      AM_INDEX: begin idx = 1'b1; mode_ok = is_b; end
      default:  mode_ok = 1'b0;
    endcase
  end

  assign ea_raw  = idx ? ptr + off_i : ptr;
  assign nxt_raw = post ? (dec_i ? ptr - step : ptr + step) : ptr;
  assign ea_o    = ea_raw & EVEN;
  assign nxt_o   = nxt_raw & EVEN;

  mac_agu_win #(.AW(AW), .LO(LO), .HI(HI)) i_win (
    .a_i    (ea_o),
    .b_i    (nxt_o),
    .b_en_i (post),
    .out_o  (rng_err_o)
  );

  assign cfg_err_o = !reg_ok || !mode_ok;
  assign we_o      = post && !cfg_err_o && !rng_err_o;
endmodule

// File: rtl/mac_agu.sv
module mac_agu
  import mac_agu_pkg::*;
#(
  parameter int unsigned   AW     = 16,
  parameter int unsigned   RW     = 4,
  parameter logic [RW-1:0] X0_REG = 4'd8,
  parameter logic [RW-1:0] X1_REG = 4'd9,
  parameter logic [RW-1:0] Y0_REG = 4'd10,
  parameter logic [RW-1:0] Y1_REG = 4'd11,
  parameter logic [AW-1:0] X_LO   = 16'h0800,
  parameter logic [AW-1:0] X_HI   = 16'h17FF,
  parameter logic [AW-1:0] Y_LO   = 16'h1800,
  parameter logic [AW-1:0] Y_HI   = 16'h1FFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] x_sel_i,
  input  logic [2:0]    x_mode_i,
  input  logic          x_dec_i,
  input  logic [RW-1:0] y_sel_i,
  input  logic [2:0]    y_mode_i,
  input  logic          y_dec_i,
  input  logic [AW-1:0] ptr_x0_i,
  input  logic [AW-1:0] ptr_x1_i,
  input  logic [AW-1:0] ptr_y0_i,
  input  logic [AW-1:0] ptr_y1_i,
  input  logic [AW-1:0] offset_i,
  output logic [AW-1:0] x_addr_o,
  output logic [AW-1:0] x_wb_o,
  output logic          x_we_o,
  output logic [RW-1:0] x_wb_reg_o,
  output logic [AW-1:0] y_addr_o,
  output logic [AW-1:0] y_wb_o,
  output logic          y_we_o,
  output logic [RW-1:0] y_wb_reg_o,
  output logic          cfg_err_o,
  output logic          range_err_o
);
  logic [NLANE-1:0][RW-1:0] sel;
  logic [NLANE-1:0][2:0]    mode;
  logic [NLANE-1:0]         dec, we, cerr, rerr;
  logic [NLANE-1:0][AW-1:0] pa, pb, ea, nxt;

  assign sel  = {y_sel_i, x_sel_i};
  assign mode = {y_mode_i, x_mode_i};
  assign dec  = {y_dec_i, x_dec_i};
  assign pa   = {ptr_y0_i, ptr_x0_i};
  assign pb   = {ptr_y1_i, ptr_x1_i};

  // lane 0 = X space, lane 1 = Y space
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam logic [RW-1:0] RA = (g == 0) ? X0_REG : Y0_REG;
    localparam logic [RW-1:0] RB = (g == 0) ? X1_REG : Y1_REG;
    localparam logic [AW-1:0] LO = (g == 0) ? X_LO : Y_LO;
    localparam logic [AW-1:0] HI = (g == 0) ? X_HI : Y_HI;
    mac_agu_lane #(
      .AW(AW), .RW(RW), .REG_A(RA), .REG_B(RB), .LO(LO), .HI(HI)
    ) i_lane (
      .sel_i     (sel[g]),
      .mode_i    (mode[g]),
      .dec_i     (dec[g]),
      .ptr_a_i   (pa[g]),
      .ptr_b_i   (pb[g]),
      .off_i     (offset_i),
      .ea_o      (ea[g]),
      .nxt_o     (nxt[g]),
      .we_o      (we[g]),
      .cfg_err_o (cerr[g]),
      .rng_err_o (rerr[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_addr_o    <= '0;
      x_wb_o      <= '0;
      x_we_o      <= 1'b0;
      x_wb_reg_o  <= '0;
      y_addr_o    <= '0;
      y_wb_o      <= '0;
      y_we_o      <= 1'b0;
      y_wb_reg_o  <= '0;
      cfg_err_o   <= 1'b0;
      range_err_o <= 1'b0;
    end else begin
      x_addr_o    <= ea[0];
      x_wb_o      <= nxt[0];
      x_we_o      <= we[0];
      x_wb_reg_o  <= sel[0];
      y_addr_o    <= ea[1];
      y_wb_o      <= nxt[1];
      y_we_o      <= we[1];
      y_wb_reg_o  <= sel[1];
      cfg_err_o   <= |cerr;
      range_err_o <= |rerr;
    end
  end
endmodule

// File: rtl/mac_agu_chk.sv
module mac_agu_chk #(
  parameter int unsigned   AW     = 16,
  parameter int unsigned   RW     = 4,
  parameter logic [RW-1:0] X0_REG = 4'd8,
  parameter logic [RW-1:0] X1_REG = 4'd9,
  parameter logic [RW-1:0] Y0_REG = 4'd10,
  parameter logic [RW-1:0] Y1_REG = 4'd11,
  parameter logic [AW-1:0] X_LO   = '0,
  parameter logic [AW-1:0] X_HI   = '1,
  parameter logic [AW-1:0] Y_LO   = '0,
  parameter logic [AW-1:0] Y_HI   = '1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [RW-1:0] x_sel_i,
  input logic [2:0]    x_mode_i,
  input logic [RW-1:0] y_sel_i,
  input logic [2:0]    y_mode_i,
  input logic [AW-1:0] x_addr_o,
  input logic [AW-1:0] x_wb_o,
  input logic          x_we_o,
  input logic [RW-1:0] x_wb_reg_o,
  input logic [AW-1:0] y_addr_o,
  input logic [AW-1:0] y_wb_o,
  input logic          y_we_o,
  input logic [RW-1:0] y_wb_reg_o,
  input logic          cfg_err_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  logic [AW-1:0] dx, dy;
  logic          dx_ok, dy_ok;
  assign dx = x_wb_o - x_addr_o;
  assign dy = y_wb_o - y_addr_o;
  assign dx_ok = dx == AW'(2) || dx == AW'(4) || dx == AW'(6) ||
                 (-dx) == AW'(2) || (-dx) == AW'(4) || (-dx) == AW'(6);
  assign dy_ok = dy == AW'(2) || dy == AW'(4) || dy == AW'(6) ||
                 (-dy) == AW'(2) || (-dy) == AW'(4) || (-dy) == AW'(6);

  p_even_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !x_addr_o[0] && !y_addr_o[0] && !x_wb_o[0] && !y_wb_o[0]);

  p_x_reg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(x_sel_i != X0_REG && x_sel_i != X1_REG) |-> cfg_err_o && !x_we_o);

  p_y_reg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(y_sel_i != Y0_REG && y_sel_i != Y1_REG) |-> cfg_err_o && !y_we_o);

  p_x_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_we_o |-> dx_ok);

  p_y_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_we_o |-> dy_ok);

  p_idx_no_we_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(x_mode_i == 3'd4 || y_mode_i == 3'd4) |->
      !($past(x_mode_i == 3'd4) && x_we_o) && !($past(y_mode_i == 3'd4) && y_we_o));

  p_x_win_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_we_o |-> x_wb_o >= X_LO && x_wb_o <= X_HI && x_addr_o >= X_LO && x_addr_o <= X_HI);

  p_y_win_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_we_o |-> y_wb_o >= Y_LO && y_wb_o <= Y_HI && y_addr_o >= Y_LO && y_addr_o <= Y_HI);

  p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> x_wb_reg_o == $past(x_sel_i) && y_wb_reg_o == $past(y_sel_i));
endmodule

bind mac_agu mac_agu_chk #(
  .AW(AW), .RW(RW), .X0_REG(X0_REG), .X1_REG(X1_REG), .Y0_REG(Y0_REG), .Y1_REG(Y1_REG),
  .X_LO(X_LO), .X_HI(X_HI), .Y_LO(Y_LO), .Y_HI(Y_HI)
) i_mac_agu_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .x_sel_i(x_sel_i), .x_mode_i(x_mode_i), .y_sel_i(y_sel_i), .y_mode_i(y_mode_i),
  .x_addr_o(x_addr_o), .x_wb_o(x_wb_o), .x_we_o(x_we_o), .x_wb_reg_o(x_wb_reg_o),
  .y_addr_o(y_addr_o), .y_wb_o(y_wb_o), .y_we_o(y_we_o), .y_wb_reg_o(y_wb_reg_o),
  .cfg_err_o(cfg_err_o)
);

// File: tb/test_mac_agu.sv
`timescale 1ns/1ps
module test_mac_agu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  x_sel_i = 4'd8, y_sel_i = 4'd10;
  logic [2:0]  x_mode_i = '0, y_mode_i = '0;
  logic        x_dec_i = 1'b0, y_dec_i = 1'b0;
  logic [15:0] ptr_x0_i = '0, ptr_x1_i = '0, ptr_y0_i = '0, ptr_y1_i = '0, offset_i = '0;
  logic [15:0] x_addr_o, x_wb_o, y_addr_o, y_wb_o;
  logic        x_we_o, y_we_o, cfg_err_o, range_err_o;
  logic [3:0]  x_wb_reg_o, y_wb_reg_o;

  always #2.5 clk_i = ~clk_i;

  mac_agu #(
    .X_LO(16'h0100), .X_HI(16'h01FF), .Y_LO(16'h0200), .Y_HI(16'h02FF)
  ) i_mac_agu (.*);

  typedef struct packed {
    logic [7:0]  req;
    logic [3:0]  xs; logic [2:0] xm; logic xd;
    logic [3:0]  ys; logic [2:0] ym; logic yd;
    logic [15:0] p0, p1, p2, p3, off;
    logic [15:0] xa, xw; logic xe;
    logic [15:0] ya, yw; logic ye;
    logic        ce, re;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3, 8,0,0, 10,0,0, 16'h0110,16'h0120,16'h0210,16'h0220,16'h0010, 16'h0110,16'h0110,0, 16'h0210,16'h0210,0, 0,0}, // R3
    '{4, 9,1,0, 11,2,1, 16'h0110,16'h0120,16'h0210,16'h0220,16'h0010, 16'h0120,16'h0122,1, 16'h0220,16'h021C,1, 0,0}, // R4
    '{4, 8,3,1, 10,3,0, 16'h0110,16'h0120,16'h0210,16'h0220,16'h0010, 16'h0110,16'h010A,1, 16'h0210,16'h0216,1, 0,0}, // R4
    '{5, 9,4,0, 11,4,0, 16'h0110,16'h0120,16'h0210,16'h0220,16'h0010, 16'h0130,16'h0120,0, 16'h0230,16'h0220,0, 0,0}, // R5
    '{5, 8,4,0, 10,0,0, 16'h0110,16'h0120,16'h0210,16'h0220,16'h0010, 16'h0120,16'h0110,0, 16'h0210,16'h0210,0, 1,0}, // R5
    '{2, 10,1,0, 10,1,0, 16'h0110,16'h0120,16'h0210,16'h0220,16'h0010, 16'h0110,16'h0112,0, 16'h0210,16'h0212,1, 1,0}, // R2 R8
    '{8, 8,1,0, 8,0,0, 16'h0110,16'h0120,16'h0210,16'h0220,16'h0010, 16'h0110,16'h0112,1, 16'h0210,16'h0210,0, 1,0}, // R2 R8
    '{5, 9,5,0, 11,0,0, 16'h0110,16'h0120,16'h0210,16'h0220,16'h0010, 16'h0120,16'h0120,0, 16'h0220,16'h0220,0, 1,0}, // R5
    '{6, 9,1,0, 11,4,0, 16'h0110,16'h0125,16'h0210,16'h0223,16'h0011, 16'h0124,16'h0126,1, 16'h0234,16'h0222,0, 0,0}, // R6
    '{7, 8,1,0, 10,0,0, 16'h01FE,16'h0120,16'h0210,16'h0220,16'h0010, 16'h01FE,16'h0200,0, 16'h0210,16'h0210,0, 0,1}, // R7
    '{7, 8,0,0, 11,4,0, 16'h0110,16'h0120,16'h0210,16'h02F8,16'h0010, 16'h0110,16'h0110,0, 16'h0308,16'h02F8,0, 0,1}, // R7
    '{7, 8,2,1, 10,1,1, 16'h0100,16'h0120,16'h0200,16'h0220,16'h0010, 16'h0100,16'h00FC,0, 16'h0200,16'h01FE,0, 0,1}, // R7
    '{7, 8,2,0, 10,2,0, 16'h01FA,16'h0120,16'h02FA,16'h0220,16'h0010, 16'h01FA,16'h01FE,1, 16'h02FA,16'h02FE,1, 0,0}, // R7
    '{7, 9,0,0, 10,0,0, 16'h0110,16'h0050,16'h0210,16'h0220,16'h0010, 16'h0050,16'h0050,0, 16'h0210,16'h0210,0, 0,1}  // R7
  };

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    x_sel_i = v.xs; x_mode_i = v.xm; x_dec_i = v.xd;
    y_sel_i = v.ys; y_mode_i = v.ym; y_dec_i = v.yd;
    ptr_x0_i = v.p0; ptr_x1_i = v.p1; ptr_y0_i = v.p2; ptr_y1_i = v.p3; offset_i = v.off;
  endtask

  task automatic chk_zero(input string req);
    chk(req, "zero outputs",
        {x_addr_o | x_wb_o | y_addr_o | y_wb_o, 4'(x_wb_reg_o | y_wb_reg_o),
         x_we_o, y_we_o, cfg_err_o, range_err_o}, '0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    drive(VECS[1]);
    repeat (3) @(negedge clk_i);
    chk_zero("R1");  // R1 held in reset with live inputs
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string r;
      @(negedge clk_i);
      drive(VECS[i]);
      @(negedge clk_i);
      r = $sformatf("R%0d", VECS[i].req);
      chk(r, "x_addr", x_addr_o, VECS[i].xa);
      chk(r, "x_wb",   x_wb_o,   VECS[i].xw);
      chk(r, "x_we",   x_we_o,   VECS[i].xe);
      chk(r, "x_reg",  x_wb_reg_o, VECS[i].xs);
      chk(r, "y_addr", y_addr_o, VECS[i].ya);
      chk(r, "y_wb",   y_wb_o,   VECS[i].yw);
      chk(r, "y_we",   y_we_o,   VECS[i].ye);
      chk(r, "y_reg",  y_wb_reg_o, VECS[i].ys);
      chk(r, "cfg_err", cfg_err_o, VECS[i].ce);
      chk(r, "range_err", range_err_o, VECS[i].re);
    end

    // R9: new inputs are not visible before the next rising edge
    @(negedge clk_i);
    drive(VECS[1]);
    @(negedge clk_i);
    drive(VECS[0]);
    #1;
    chk("R9", "x_we before edge", x_we_o, 1'b1);
    chk("R9", "y_wb before edge", y_wb_o, 16'h021C);
    @(negedge clk_i);
    chk("R9", "x_we after edge", x_we_o, 1'b0);
    chk("R9", "y_wb after edge", y_wb_o, 16'h0210);

    // R1: reset in the middle of operation clears the outputs
    drive(VECS[5]);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk_zero("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R2", "cfg_err after reset", cfg_err_o, 1'b1);
    chk("R8", "y_we after reset", y_we_o, 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule